// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

A 16x16 multiplier with a 48-bit accumulator. It sits on a plain 16-bit register bus with a 3-bit word address, a write strobe, write data and combinational read data. Software writes a control word that picks the operation. It then writes the operands, and the write that supplies the last operand starts the operation. The product register and the accumulator hold the result right after the clock edge that takes the triggering write, so the next bus cycle can read it.

The unit can multiply, multiply-accumulate or multiply-subtract, with signed or unsigned operands. It also has a signed multiply-negate mode, which can copy its result into the accumulator. A square mode feeds the first operand to both multiplier inputs. Accumulator overflow is caught for both signed and unsigned arithmetic and stays flagged until software writes the control word.

Top module: `mac_unit`

## Requirements
- R1: After reset, every readable word (control, both operands, the three accumulator words and the two product words) reads 0.
- R2: Word addresses: 0 control, 1 operand A, 2 operand B, 3/4/5 accumulator bits 15:0, 31:16 and 47:32, 6/7 product bits 15:0 and 31:16. Operand and accumulator words read back what was last written to them. The control word reads back bits 0 (signed), 1 (accumulate), 2 (subtract), 3 (two-operand count), 4 (square) and 6 (negate-to-accumulator) as written.
- R3: Writes to addresses 6 and 7 are ignored. The product register changes only when an operation fires.
- R4: With bit 3 clear, a write to A fires the operation using the stored B. A write to B alone fires nothing.
- R5: With bit 3 set and bit 4 clear, the operation fires on the write that completes a pair of A and B writes, in either order. A single write fires nothing. A control write discards a half-loaded pair.
- R6: With bit 4 set, a write to A fires with A used as both inputs. Writes to B never fire.
- R7: Bit 0 selects a two's-complement or an unsigned product. Before the accumulator adds or subtracts it, the 32-bit product is sign-extended to 48 bits when signed and zero-extended when unsigned.
- R8: Bits 1 and 2 = 10 adds the product to the accumulator. 11 subtracts it. 00 only multiplies and leaves the accumulator unchanged.
- R9: Bits 1 and 2 = 01 is a signed multiply-negate. The product register takes the negated product. When bit 6 is set, the accumulator also takes the negated product, sign-extended.
- R10: Control bit 15 is set when an accumulate or subtract overflows: a sign overflow for signed operations, a carry or borrow out of bit 47 for unsigned ones. It stays set until the next control write, which clears it.
- R11: Writing control bit 5 clears the accumulator at that edge. Bit 5 always reads 0.
- R12: The result of an operation can be read in the bus cycle right after the write that fired it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word (combinational) |

## Verification
The bound checker watches the following on every cycle:
- a control write clears the overflow flag, and the flag holds until then;
- the clear bit empties the accumulator;
- the product register ignores bus writes;
- the accumulator holds unless an operation, a control write or an accumulator-word write occurs;
- in single-operand and square modes an A write fires, and nothing fires without an operand write.

The arithmetic values can only be shown by the bench's scenarios. These cover:
- signed and unsigned products and how they are extended;
- accumulate and subtract sums;
- the negate result;
- the difference between signed and unsigned overflow at the same accumulator value;
- the pairing of operand writes in two-operand mode.

// File: rtl/mac_pkg.sv
package mac_pkg;
   // control word bit positions (overflow sits in the top bit of the word)
   localparam int CB_SGN  = 0;
   localparam int CB_ACC  = 1;
   localparam int CB_SUB  = 2;
   localparam int CB_PAIR = 3;
   localparam int CB_SQR  = 4;
   localparam int CB_CLR  = 5;
   localparam int CB_NACC = 6;

   typedef struct packed {
      logic nacc;
      logic sqr;
      logic pair;
      logic sub;
      logic acc;
      logic sgn;
   } mac_ctrl_t;

   typedef enum logic [1:0] {
      OP_MUL = 2'd0,
      OP_MAC = 2'd1,
      OP_MSU = 2'd2,
      OP_NEG = 2'd3
   } mac_op_e;

   function automatic mac_op_e op_of(mac_ctrl_t c);
      if (c.acc) return c.sub ? OP_MSU : OP_MAC;
      return c.sub ? OP_NEG : OP_MUL;
   endfunction
endpackage

// File: rtl/mac_trigger.sv
module mac_trigger #(
   parameter int OP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_ctrl,
   input  logic            wr_a,
   input  logic            wr_b,
   input  logic            pair,
   input  logic            sqr,
   input  logic [OP_W-1:0] wdata,
   output logic [OP_W-1:0] opa_q,
   output logic [OP_W-1:0] opb_q,
   output logic [OP_W-1:0] mul_a,
   output logic [OP_W-1:0] mul_b,
   output logic            fire
);
   logic seen_a, seen_b;

   // fire decision from the current write and the pair-tracking flags
   assign fire = (wr_a & (sqr | ~pair | seen_b)) |
                 (wr_b & ~sqr & pair & seen_a);

   // operands as they stand after this cycle's write
   assign mul_a = wr_a ? wdata : opa_q;
   assign mul_b = sqr ? mul_a : (wr_b ? wdata : opb_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opa_q  <= '0;
         opb_q  <= '0;
         seen_a <= 1'b0;
         seen_b <= 1'b0;
      end else begin
         if (wr_a) opa_q <= wdata;
         if (wr_b) opb_q <= wdata;
         if (wr_ctrl || fire) begin
            seen_a <= 1'b0;
            seen_b <= 1'b0;
         end else begin
            if (wr_a && pair) seen_a <= 1'b1;
            if (wr_b && pair) seen_b <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int OP_W      = 16,
   parameter bit USE_ARRAY = 1'b0,
   localparam int PW       = 2 * OP_W
) (
   input  logic [OP_W-1:0] a,
   input  logic [OP_W-1:0] b,
   input  logic            sgn,
   output logic [PW-1:0]   p
);
   logic [PW-1:0] ae, be;

   // extend both operands to product width; low PW bits are then correct
   assign ae = {{OP_W{sgn & a[OP_W-1]}}, a};
   assign be = {{OP_W{sgn & b[OP_W-1]}}, b};

   if (USE_ARRAY) begin : g_array
      logic [PW-1:0] pp [PW];
      for (genvar i = 0; i < PW; i++) begin : g_pp
         assign pp[i] = ae[i] ? (be << i) : '0;
      end
      always_comb begin
         p = '0;
         for (int k = 0; k < PW; k++) p = p + pp[k];
      end
   end else begin : g_native
      assign p = ae * be;
   end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
   parameter int ACC_W = 48,
   parameter int PW    = 32
) (
   input  logic [ACC_W-1:0] acc,
   input  logic [PW-1:0]    prod,
   input  logic             sgn,
   input  logic             sub,
   output logic [ACC_W-1:0] res,
   output logic             ovf
);
   localparam int MSB = ACC_W - 1;

   logic [ACC_W-1:0] ext;
   logic [ACC_W:0]   wide;
   logic             s_ovf;

   assign ext  = {{(ACC_W-PW){sgn & prod[PW-1]}}, prod};
   assign wide = sub ? ({1'b0, acc} - {1'b0, ext}) : ({1'b0, acc} + {1'b0, ext});
   assign res  = wide[MSB:0];

   always_comb begin
      if (sub) s_ovf = (acc[MSB] != ext[MSB]) && (wide[MSB] != acc[MSB]);
      else     s_ovf = (acc[MSB] == ext[MSB]) && (wide[MSB] != acc[MSB]);
   end

   assign ovf = sgn ? s_ovf : wide[ACC_W];
endmodule

// File: rtl/mac_unit.sv
module mac_unit
   import mac_pkg::*;
#(
   parameter int  OP_W      = 16,
   parameter int  ACC_WORDS = 3,
   parameter bit  USE_ARRAY = 1'b0,
   localparam int AW        = $clog2(5 + ACC_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   bus_addr,
   input  logic            bus_wr,
   input  logic [OP_W-1:0] bus_wdata,
   output logic [OP_W-1:0] bus_rdata
);
   localparam int PW     = 2 * OP_W;
   localparam int ACC_W  = ACC_WORDS * OP_W;
   localparam int A_CTRL = 0;
   localparam int A_OPA  = 1;
   localparam int A_OPB  = 2;
   localparam int A_ACC0 = 3;
   localparam int A_PRD0 = A_ACC0 + ACC_WORDS;

   if (OP_W < 8) begin : g_bad_opw
      $error("mac_unit: OP_W must be at least 8");
   end
   if (ACC_WORDS < 2) begin : g_bad_acc
      $error("mac_unit: accumulator must hold at least the full product");
   end

   mac_ctrl_t       ctrl_q;
   logic            ovf_q;
   logic [ACC_W-1:0] acc_q;
   logic [PW-1:0]   prod_q;

   logic            wr_ctrl, wr_a, wr_b, fire;
   logic [OP_W-1:0] opa_q, opb_q, mul_a, mul_b;
   logic [PW-1:0]   mul_p, prod_neg;
   logic [ACC_W-1:0] acc_res, neg_ext;
   logic            acc_ovf, sgn_eff;
   mac_op_e         op;

   assign wr_ctrl = bus_wr && (int'(bus_addr) == A_CTRL);
   assign wr_a    = bus_wr && (int'(bus_addr) == A_OPA);
   assign wr_b    = bus_wr && (int'(bus_addr) == A_OPB);

   assign op      = op_of(ctrl_q);
   assign sgn_eff = ctrl_q.sgn | (op == OP_NEG);

   mac_trigger #(.OP_W(OP_W)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_a    (wr_a),
      .wr_b    (wr_b),
      .pair    (ctrl_q.pair),
      .sqr     (ctrl_q.sqr),
      .wdata   (bus_wdata),
      .opa_q   (opa_q),
      .opb_q   (opb_q),
      .mul_a   (mul_a),
      .mul_b   (mul_b),
      .fire    (fire)
   );

   mac_mult #(.OP_W(OP_W), .USE_ARRAY(USE_ARRAY)) u_mult (
      .a   (mul_a),
      .b   (mul_b),
      .sgn (sgn_eff),
      .p   (mul_p)
   );

   mac_accum #(.ACC_W(ACC_W), .PW(PW)) u_acc (
      .acc  (acc_q),
      .prod (mul_p),
      .sgn  (ctrl_q.sgn),
      .sub  (ctrl_q.sub),
      .res  (acc_res),
      .ovf  (acc_ovf)
   );

   assign prod_neg = PW'(0) - mul_p;
   assign neg_ext  = {{(ACC_W-PW){prod_neg[PW-1]}}, prod_neg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ovf_q  <= 1'b0;
         acc_q  <= '0;
         prod_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.sgn  <= bus_wdata[CB_SGN];
            ctrl_q.acc  <= bus_wdata[CB_ACC];
            ctrl_q.sub  <= bus_wdata[CB_SUB];
            ctrl_q.pair <= bus_wdata[CB_PAIR];
            ctrl_q.sqr  <= bus_wdata[CB_SQR];
            ctrl_q.nacc <= bus_wdata[CB_NACC];
            ovf_q       <= 1'b0;
            if (bus_wdata[CB_CLR]) acc_q <= '0;
         end
         for (int k = 0; k < ACC_WORDS; k++) begin
            if (bus_wr && (int'(bus_addr) == A_ACC0 + k))
               acc_q[k*OP_W +: OP_W] <= bus_wdata;
         end
         if (fire) begin
            prod_q <= (op == OP_NEG) ? prod_neg : mul_p;
            case (op)
               OP_MAC, OP_MSU: begin
                  acc_q <= acc_res;
                  ovf_q <= ovf_q | acc_ovf;
               end
               OP_NEG: if (ctrl_q.nacc) acc_q <= neg_ext;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (int'(bus_addr) == A_CTRL) begin
         bus_rdata[CB_SGN]  = ctrl_q.sgn;
         bus_rdata[CB_ACC]  = ctrl_q.acc;
         bus_rdata[CB_SUB]  = ctrl_q.sub;
         bus_rdata[CB_PAIR] = ctrl_q.pair;
         bus_rdata[CB_SQR]  = ctrl_q.sqr;
         bus_rdata[CB_NACC] = ctrl_q.nacc;
         bus_rdata[OP_W-1]  = ovf_q;
      end
      if (int'(bus_addr) == A_OPA) bus_rdata = opa_q;
      if (int'(bus_addr) == A_OPB) bus_rdata = opb_q;
      for (int k = 0; k < ACC_WORDS; k++)
         if (int'(bus_addr) == A_ACC0 + k) bus_rdata = acc_q[k*OP_W +: OP_W];
      for (int j = 0; j < 2; j++)
         if (int'(bus_addr) == A_PRD0 + j) bus_rdata = prod_q[j*OP_W +: OP_W];
   end
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
   parameter int OP_W      = 16,
   parameter int ACC_W     = 48,
   parameter int AW        = 3,
   parameter int ACC_WORDS = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:0]   bus_addr,
   input logic            bus_wr,
   input logic [OP_W-1:0] bus_wdata,
   input logic [OP_W-1:0] bus_rdata,
   input logic            fire,
   input logic            pair,
   input logic            sqr,
   input logic            ovf_q,
   input logic [ACC_W-1:0] acc_q,
   input logic [2*OP_W-1:0] prod_q
);
   localparam int A_ACC0 = 3;
   localparam int A_PRD0 = A_ACC0 + ACC_WORDS;

   logic ctrl_wr, acc_wr, prd_wr, opa_wr, op_wr;
   assign ctrl_wr = bus_wr && (int'(bus_addr) == 0);
   assign opa_wr  = bus_wr && (int'(bus_addr) == 1);
   assign op_wr   = bus_wr && ((int'(bus_addr) == 1) || (int'(bus_addr) == 2));
   assign acc_wr  = bus_wr && (int'(bus_addr) >= A_ACC0) && (int'(bus_addr) < A_PRD0);
   assign prd_wr  = bus_wr && (int'(bus_addr) >= A_PRD0);

   assert_clr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && bus_wdata[5] |=> acc_q == '0);

   assert_clr_reads0_R11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(bus_addr) == 0 |-> !bus_rdata[5]);

   assert_prod_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
      prd_wr |=> $stable(prod_q));

   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q && !ctrl_wr |=> ovf_q);

   assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> !ovf_q);

   assert_single_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
      opa_wr && (!pair || sqr) |-> fire);

   assert_fire_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> op_wr);

   assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !fire && !ctrl_wr && !acc_wr |=> $stable(acc_q));
endmodule

bind mac_unit mac_checker #(
   .OP_W(OP_W), .ACC_W(ACC_W), .AW(AW), .ACC_WORDS(ACC_WORDS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .fire      (fire),
   .pair      (ctrl_q.pair),
   .sqr       (ctrl_q.sqr),
   .ovf_q     (ovf_q),
   .acc_q     (acc_q),
   .prod_q    (prod_q)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        rd_strobe = 1'b0;

   always #2 clk = ~clk;

   mac_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   typedef struct {
      logic [2:0]  ad;
      logic [15:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int n_tests = 0;
   int n_fail  = 0;
   bit ended   = 0;

   // reference state
   logic [6:0]  m_ctrl = '0;
   logic        m_ovf  = 1'b0;
   logic [15:0] m_a = '0, m_b = '0;
   logic [47:0] m_acc = '0;
   logic [31:0] m_prod = '0;
   bit          sa = 0, sb = 0;

   task automatic model_fire();
      logic        sgn, neg, ov;
      logic [15:0] a, b;
      logic [31:0] p, np;
      logic [47:0] ext;
      logic [48:0] w;
      neg = !m_ctrl[1] && m_ctrl[2];
      sgn = m_ctrl[0] || neg;
      a = m_a;
      b = m_ctrl[4] ? m_a : m_b;
      if (sgn) p = $signed(a) * $signed(b);
      else     p = {16'h0, a} * {16'h0, b};
      if (neg) begin
         np = 32'h0 - p;
         m_prod = np;
         if (m_ctrl[6]) m_acc = {{16{np[31]}}, np};
      end else begin
         m_prod = p;
         if (m_ctrl[1]) begin
            ext = m_ctrl[0] ? {{16{p[31]}}, p} : {16'h0, p};
            w = m_ctrl[2] ? ({1'b0, m_acc} - {1'b0, ext}) : ({1'b0, m_acc} + {1'b0, ext});
            if (m_ctrl[0]) begin
               if (m_ctrl[2]) ov = (m_acc[47] != ext[47]) && (w[47] != m_acc[47]);
               else           ov = (m_acc[47] == ext[47]) && (w[47] != m_acc[47]);
            end else ov = w[48];
            m_acc = w[47:0];
            m_ovf = m_ovf | ov;
         end
      end
      sa = 0; sb = 0;
   endtask

   task automatic model_write(input logic [2:0] ad, input logic [15:0] d);
      bit pair, sqr;
      pair = m_ctrl[3]; sqr = m_ctrl[4];
      case (ad)
         3'd0: begin
            m_ctrl = {d[6], d[4:0]} == 6'h0 ? 7'h0 : {d[6], 1'b0, d[4:0]};
            m_ovf = 1'b0;
            if (d[5]) m_acc = '0;
            sa = 0; sb = 0;
         end
         3'd1: begin
            m_a = d;
            if (sqr || !pair || sb) model_fire();
            else sa = 1;
         end
         3'd2: begin
            m_b = d;
            if (!sqr && pair) begin
               if (sa) model_fire();
               else sb = 1;
            end
         end
         3'd3: m_acc[15:0]  = d;
         3'd4: m_acc[31:16] = d;
         3'd5: m_acc[47:32] = d;
         default: ;
      endcase
   endtask

   task automatic wr(input logic [2:0] ad, input logic [15:0] d);
      @(posedge clk); #1;
      rd_strobe = 1'b0;
      bus_addr = ad; bus_wr = 1'b1; bus_wdata = d;
      model_write(ad, d);
   endtask

   task automatic rd(input logic [2:0] ad, input logic [15:0] exp, input string tag);
      sb_item_t it;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = ad; rd_strobe = 1'b1;
      it.ad = ad; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic check_all(input string tag);
      rd(3'd0, {m_ovf, 8'h0, m_ctrl}, tag);
      rd(3'd1, m_a, tag);
      rd(3'd2, m_b, tag);
      rd(3'd3, m_acc[15:0], tag);
      rd(3'd4, m_acc[31:16], tag);
      rd(3'd5, m_acc[47:32], tag);
      rd(3'd6, m_prod[15:0], tag);
      rd(3'd7, m_prod[31:16], tag);
   endtask

   // monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      if (rd_strobe && !ended) begin
         sb_item_t it;
         if (sb_q.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL scoreboard: read with no expected item");
         end else begin
            it = sb_q.pop_front();
            n_tests++;
            if (bus_rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: addr %0d got %h expected %h", it.tag, it.ad, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      check_all("R1");
      // R2 accumulator words and control readback
      wr(3'd3, 16'h1111); wr(3'd4, 16'h2222); wr(3'd5, 16'h3333);
      wr(3'd0, 16'h0049);
      check_all("R2");
      wr(3'd0, 16'h0000);
      // R3 product register ignores writes
      wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
      check_all("R3");
      // R4 single operand count, unsigned (R7)
      wr(3'd2, 16'h0003);
      check_all("R4");
      wr(3'd1, 16'hFFFF);
      check_all("R4_R7_R12");
      // R5 pair mode, signed
      wr(3'd0, 16'h0009);
      wr(3'd1, 16'hFFFE);
      check_all("R5");
      wr(3'd2, 16'h0007);
      check_all("R5");
      wr(3'd2, 16'h0100);
      wr(3'd1, 16'h0100);
      check_all("R5");
      // R6 square
      wr(3'd0, 16'h0011);
      wr(3'd2, 16'h0005);
      wr(3'd1, 16'h8000);
      check_all("R6");
      // R11 clear, then R8 signed accumulate
      wr(3'd0, 16'h0023);
      check_all("R11");
      wr(3'd1, 16'hFFFD);
      check_all("R8");
      wr(3'd1, 16'h0002);
      check_all("R8");
      // R10 unsigned subtract borrow, sticky, cleared
      wr(3'd0, 16'h0026);
      wr(3'd2, 16'h0001);
      wr(3'd1, 16'h0001);
      check_all("R10");
      wr(3'd1, 16'h0000);
      check_all("R10");
      wr(3'd0, 16'h0006);
      check_all("R10");
      // R10 signed add overflow
      wr(3'd0, 16'h0003);
      wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF); wr(3'd5, 16'h7FFF);
      wr(3'd1, 16'h0001);
      check_all("R10");
      // same sum unsigned: no overflow
      wr(3'd0, 16'h0002);
      wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF); wr(3'd5, 16'h7FFF);
      wr(3'd1, 16'h0001);
      check_all("R10");
      // R7 zero extension vs signed
      wr(3'd0, 16'h0022);
      wr(3'd2, 16'hFFFF);
      wr(3'd1, 16'hFFFF);
      check_all("R7");
      wr(3'd0, 16'h0023);
      wr(3'd1, 16'hFFFF);
      check_all("R7");
      // R9 negate, then into accumulator
      wr(3'd0, 16'h0004);
      wr(3'd2, 16'h0003);
      wr(3'd1, 16'h0005);
      check_all("R9");
      wr(3'd0, 16'h0044);
      wr(3'd1, 16'h0005);
      check_all("R9");
      wr(3'd1, 16'hFFFF);
      check_all("R9");
      @(posedge clk); #1;
      rd_strobe = 1'b0; bus_wr = 1'b0;
      repeat (3) @(posedge clk);
      if (sb_q.size() != 0) begin
         n_tests++; n_fail++;
         $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
      end
      finish_run();
   end
endmodule